// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Bus Controller

This block sits between a synchronous system port and an external asynchronous static RAM. The RAM is eight bits wide and has a 21-bit address. A client presents one read or one write at a time on a valid/ready handshake. The controller then drives the RAM's active-low chip, write and output enables through a timed sequence. Every phase of that sequence lasts a whole number of system clock cycles. Each such count is derived from a nanosecond limit and the clock period. It is the nanosecond limit divided by the period, rounded up, and never less than one cycle.

The controller owns the data bus. It drives write data only while a write is in progress. During every write it keeps output enable high, so the RAM never drives the bus against it. When a read follows a write, or a write follows a read, the controller first waits a turnaround period with the bus released and all enables high. Read data is sampled into a register at the end of the access window and is presented with a single-cycle valid pulse. When there is no request, the RAM is held in standby with chip enable high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is applied and after it is released, chip, write and output enables are all high (1), the controller does not drive the data bus, `rdValid` is 0 and `reqReady` is 1.
- R2: `reqReady` is 1 only while the controller is idle. A request is taken on a clock edge where both `reqValid` and `reqReady` are 1. `reqWrite` = 1 selects a write and `reqWrite` = 0 selects a read.
- R3: A read holds chip enable and output enable low and write enable high for exactly RD_CYC consecutive cycles, with the requested address on `memAddr`. RD_CYC is the ceiling of the access time divided by the clock period, at least 1. This is 3 at the defaults.
- R4: Read data is taken from `memDqIn` at the end of the last access cycle. `rdValid` is then 1 for exactly one cycle, with that byte on `rdData`, and the controller is idle again in that cycle.
- R5: A write proceeds in this order. First come AS_CYC cycles with the address applied and all enables high. Then come WP_CYC cycles with chip and write enable low. Then one release cycle with both high. Then DH_CYC hold cycles. Write data is driven on `memDqOut` with `memDqDrive` = 1 from the first pulse cycle through the last hold cycle. At the defaults these counts are 1, 2 and 1.
- R6: Output enable is high in every cycle in which write enable is low.
- R7: The controller never drives the data bus while output enable is low. It never drives the bus during a read.
- R8: When a read follows a write, or a write follows a read, TA_CYC extra cycles are inserted before the new operation's first phase, with all enables high and the bus released. TA_CYC is 1 at the defaults. Two operations of the same kind follow each other with no extra cycles.
- R9: `memAddr` changes only after a cycle in which chip and write enable were both high. Write enable falls only on the same edge as chip enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 21 | Request byte address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle read data strobe |
| rdData | output | 8 | Captured read data |
| memAddr | output | 21 | RAM address |
| memCeN | output | 1 | RAM chip enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memOeN | output | 1 | RAM output enable, active low |
| memDqOut | output | 8 | Data the controller places on the RAM bus |
| memDqDrive | output | 1 | 1 when the controller drives the RAM bus |
| memDqIn | input | 8 | Data seen on the RAM bus |

## Verification
The read-data capture and the release of chip and output enable happen on the same clock edge. In the bench, the model of the RAM replaces the bus with a filler byte as soon as output enable is high. A capture that is one edge late therefore returns the wrong byte, and the sweep of all stored values catches it. The other coincidence is the first idle cycle after an operation, where a request of the opposite kind is taken in that very cycle. Tightly alternating writes and reads provoke it. The bench judges it by counting cycles from acceptance to the first chip-enable-low cycle, which must include exactly the turnaround count.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREL,
    ST_WHOLD
  } ctrl_state_t;

  typedef struct packed {
    logic loadReq;
    logic capRd;
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;
  } strobe_t;

  function automatic int nsToCycles(input int limitPs, input int clkPs);
    int c;
    c = (limitPs + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 3,
  parameter int WP_CYC = 2,
  parameter int AS_CYC = 1,
  parameter int DH_CYC = 1,
  parameter int TA_CYC = 1,
  parameter int CNT_W  = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strobe
);

  ctrl_state_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic pendWrite, pendWriteNext;
  logic lastWrite, lastWriteNext;
  logic haveLast, haveLastNext;
  logic capRd;

  always_comb begin
    stateNext     = state;
    cntNext       = cnt;
    pendWriteNext = pendWrite;
    lastWriteNext = lastWrite;
    haveLastNext  = haveLast;
    capRd         = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          pendWriteNext = reqWrite;
          if (haveLast && (lastWrite != reqWrite)) begin
            stateNext = ST_TURN;
            cntNext   = CNT_W'(TA_CYC - 1);
          end else if (reqWrite) begin
            stateNext = ST_WSETUP;
            cntNext   = CNT_W'(AS_CYC - 1);
          end else begin
            stateNext = ST_RD;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (cnt == '0) begin
          if (pendWrite) begin
            stateNext = ST_WSETUP;
            cntNext   = CNT_W'(AS_CYC - 1);
          end else begin
            stateNext = ST_RD;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_RD: begin
        if (cnt == '0) begin
          capRd         = 1'b1;
          stateNext     = ST_IDLE;
          lastWriteNext = 1'b0;
          haveLastNext  = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WSETUP: begin
        if (cnt == '0) begin
          stateNext = ST_WPULSE;
          cntNext   = CNT_W'(WP_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_WPULSE: begin
        if (cnt == '0) stateNext = ST_WREL;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WREL: begin
        stateNext = ST_WHOLD;
        cntNext   = CNT_W'(DH_CYC - 1);
      end
      ST_WHOLD: begin
        if (cnt == '0) begin
          stateNext     = ST_IDLE;
          lastWriteNext = 1'b1;
          haveLastNext  = 1'b1;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadReq = (state == ST_IDLE) && reqValid;
    strobe.capRd   = capRd;
    strobe.ceN     = !((stateNext == ST_RD) || (stateNext == ST_WPULSE));
    strobe.weN     = (stateNext != ST_WPULSE);
    strobe.oeN     = (stateNext != ST_RD);
    strobe.drive   = (stateNext == ST_WPULSE) || (stateNext == ST_WREL) ||
                     (stateNext == ST_WHOLD);
  end

  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      pendWrite <= 1'b0;
      lastWrite <= 1'b0;
      haveLast  <= 1'b0;
    end else begin
      state     <= stateNext;
      cnt       <= cntNext;
      pendWrite <= pendWriteNext;
      lastWrite <= lastWriteNext;
      haveLast  <= haveLastNext;
    end
  end

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqDrive,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk) begin
    if (rst) begin
      memAddr    <= '0;
      memDqOut   <= '0;
      memDqDrive <= 1'b0;
      memCeN     <= 1'b1;
      memWeN     <= 1'b1;
      memOeN     <= 1'b1;
      rdValid    <= 1'b0;
      rdData     <= '0;
    end else begin
      if (strobe.loadReq) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      if (strobe.capRd) rdData <= memDqIn;
      rdValid    <= strobe.capRd;
      memCeN     <= strobe.ceN;
      memWeN     <= strobe.weN;
      memOeN     <= strobe.oeN;
      memDqDrive <= strobe.drive;
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 4000,
  parameter int T_ACCESS_PS = 10000,
  parameter int T_PULSE_PS = 8000,
  parameter int T_ASETUP_PS = 1,
  parameter int T_DHOLD_PS = 1,
  parameter int T_TURN_PS  = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqDrive,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC = nsToCycles(T_ACCESS_PS, CLK_PS);
  localparam int WP_CYC = nsToCycles(T_PULSE_PS, CLK_PS);
  localparam int AS_CYC = nsToCycles(T_ASETUP_PS, CLK_PS);
  localparam int DH_CYC = nsToCycles(T_DHOLD_PS, CLK_PS);
  localparam int TA_CYC = nsToCycles(T_TURN_PS, CLK_PS);
  localparam int MAX_A  = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int MAX_B  = (AS_CYC > DH_CYC) ? AS_CYC : DH_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > TA_CYC) ? MAX_C : TA_CYC;
  localparam int CNT_W  = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  strobe_t strobe;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .AS_CYC(AS_CYC),
    .DH_CYC(DH_CYC), .TA_CYC(TA_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqDrive(memDqDrive), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 21
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqDrive
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCeN && !memDqDrive));

  p_rdvalid_single_r4: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    !memWeN |-> memOeN);

  p_no_fight_r7: assert property (@(posedge clk) disable iff (rst)
    memDqDrive |-> (memOeN && $past(memOeN)));

  p_addr_change_safe_r9: assert property (@(posedge clk) disable iff (rst)
    (memAddr != $past(memAddr)) |-> ($past(memCeN) && $past(memWeN)));

  p_we_with_ce_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> $fell(memCeN));

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .rdValid(rdValid),
  .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
  .memDqDrive(memDqDrive)
);

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb;

  localparam int CLK_PS = 4000;
  localparam int TACC   = 10000;
  localparam int TWP    = 8000;
  localparam int TAS    = 1;
  localparam int TDH    = 1;
  localparam int TTA    = 4000;

  function automatic int toCyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int EXP_RD = toCyc(TACC);
  localparam int EXP_WP = toCyc(TWP);
  localparam int EXP_AS = toCyc(TAS);
  localparam int EXP_DH = toCyc(TDH);
  localparam int EXP_TA = toCyc(TTA);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [20:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rdValid, memCeN, memWeN, memOeN, memDqDrive;
  logic [7:0] rdData, memDqOut, memDqIn;
  logic [20:0] memAddr;
  logic [7:0] ramArr [64];

  int checks = 0;
  int failures = 0;
  bit haveLast = 0;
  bit lastWasWrite = 0;

  always #2 clk = ~clk;

  sram_bus_ctrl #(
    .CLK_PS(CLK_PS), .T_ACCESS_PS(TACC), .T_PULSE_PS(TWP),
    .T_ASETUP_PS(TAS), .T_DHOLD_PS(TDH), .T_TURN_PS(TTA)
  ) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDqOut(memDqOut), .memDqDrive(memDqDrive), .memDqIn(memDqIn)
  );

  // RAM model: drives only in read mode, filler byte otherwise
  assign memDqIn = (!memCeN && !memOeN && memWeN) ? ramArr[memAddr[5:0]] : 8'hA5;

  always @(posedge clk) begin
    if (!memCeN && !memWeN)
      ramArr[memAddr[5:0]] <= memDqDrive ? memDqOut : 8'h5A;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [20:0] a, input logic [7:0] d);
    int turn;
    int firstWe;
    int weCnt;
    int drvCnt;
    int drvBad;
    int oeBad;
    int addrBad;
    int readyAt;
    turn = (haveLast && !lastWasWrite) ? EXP_TA : 0;
    firstWe = -1; weCnt = 0; drvCnt = 0; drvBad = 0; oeBad = 0;
    addrBad = 0; readyAt = -1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R2", "ready before write", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(posedge clk);
    for (int k = 1; k <= 60 && readyAt < 0; k++) begin
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (!memWeN) begin
        if (firstWe < 0) firstWe = k;
        weCnt++;
        if (memOeN !== 1'b1) oeBad++;
        if (memAddr !== a || memCeN !== 1'b0) addrBad++;
      end
      if (memDqDrive) begin
        drvCnt++;
        if (memDqOut !== d) drvBad++;
      end
      if (reqReady) readyAt = k;
    end
    chk(firstWe == 1 + turn + EXP_AS, "R8", "write pulse start", firstWe, 1 + turn + EXP_AS);
    chk(weCnt == EXP_WP, "R5", "write pulse length", weCnt, EXP_WP);
    chk(drvCnt == EXP_WP + 1 + EXP_DH, "R5", "data drive cycles", drvCnt, EXP_WP + 1 + EXP_DH);
    chk(drvBad == 0, "R5", "driven data mismatches", drvBad, 0);
    chk(addrBad == 0, "R5", "address or CE wrong in pulse", addrBad, 0);
    chk(oeBad == 0, "R6", "OE low during write", oeBad, 0);
    chk(readyAt == turn + EXP_AS + EXP_WP + EXP_DH + 2, "R2", "idle again after write",
        readyAt, turn + EXP_AS + EXP_WP + EXP_DH + 2);
    haveLast = 1; lastWasWrite = 1;
  endtask

  task automatic doRead(input logic [20:0] a, input logic [7:0] expData);
    int turn;
    int firstCe;
    int ceCnt;
    int drvSeen;
    int addrBad;
    int validAt;
    int readyEarly;
    logic [7:0] got;
    turn = (haveLast && lastWasWrite) ? EXP_TA : 0;
    firstCe = -1; ceCnt = 0; drvSeen = 0; addrBad = 0; validAt = -1;
    readyEarly = 0; got = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = 8'hEE;
    @(posedge clk);
    for (int k = 1; k <= 60 && validAt < 0; k++) begin
      @(negedge clk);
      if (k == 1) reqValid = 1'b0;
      if (!memCeN && !memOeN && memWeN) begin
        if (firstCe < 0) firstCe = k;
        ceCnt++;
        if (memAddr !== a) addrBad++;
      end
      if (memDqDrive) drvSeen++;
      if (rdValid) begin
        validAt = k;
        got = rdData;
        chk(reqReady == 1'b1, "R4", "idle with rdValid", int'(reqReady), 1);
      end else if (reqReady) begin
        readyEarly++;
      end
    end
    chk(firstCe == 1 + turn, "R8", "read start", firstCe, 1 + turn);
    chk(ceCnt == EXP_RD, "R3", "read access length", ceCnt, EXP_RD);
    chk(addrBad == 0, "R3", "read address wrong", addrBad, 0);
    chk(drvSeen == 0, "R7", "bus driven during read", drvSeen, 0);
    chk(readyEarly == 0, "R2", "ready while busy", readyEarly, 0);
    chk(validAt == 1 + turn + EXP_RD, "R4", "rdValid cycle", validAt, 1 + turn + EXP_RD);
    chk(got == expData, "R4", "read data", int'(got), int'(expData));
    @(negedge clk);
    chk(rdValid == 1'b0, "R4", "rdValid width", int'(rdValid), 0);
    haveLast = 1; lastWasWrite = 0;
  endtask

  function automatic logic [20:0] addrOf(input int i);
    return 21'(i) | (21'(i % 4) << 19) | (21'(i % 3) << 10);
  endfunction

  function automatic logic [7:0] patA(input int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset held
    chk(memCeN && memWeN && memOeN, "R1", "enables in reset",
        int'({memCeN, memWeN, memOeN}), 7);
    chk(!memDqDrive && !rdValid, "R1", "drive/rdValid in reset",
        int'({memDqDrive, rdValid}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(memCeN && memWeN && memOeN && reqReady, "R1", "idle after reset",
        int'({memCeN, memWeN, memOeN, reqReady}), 15);
    chk(!memDqDrive, "R1", "bus released after reset", int'(memDqDrive), 0);

    for (int i = 0; i < 64; i++) doWrite(addrOf(i), patA(i));
    for (int i = 0; i < 64; i++) doRead(addrOf(i), patA(i));
    for (int i = 0; i < 16; i++) begin
      doWrite(addrOf(i + 40), ~patA(i + 40));
      doRead(addrOf(i + 40), ~patA(i + 40));
    end
    doRead(addrOf(20), patA(20));
    doRead(addrOf(41), ~patA(41));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule